// File: doc/BRIEF.md
# GPS Receiver Power-Up Configuration Sequencer

This block takes over a GPS receiver's serial port every time reset is released. It first waits for the receiver to settle. It then listens at the receiver's factory bit rate until it sees the line break that starts a sentence, and commands the receiver to move to a faster rate. It follows the receiver to that rate and confirms the receiver is talking there. It then sends two more commands: the first mutes every periodic sentence, the second turns the recommended-minimum sentence back on. After that it goes quiet until the next reset. If the receiver stays silent for too long in either listening step, the block parks in a fault step.

The block contains its own 16x-oversampled UART receiver and transmitter. Both run from one tick generator whose divisor is derived from the clock frequency, and one select bit switches that divisor between the slow and fast rates. A three-bit step code shows where the sequence is, so a lamp driver or a logic probe can follow it.

Top module: `gps_cfg_seq`

## Requirements
- R1: After reset, step_code is 0 and gps_txd stays high for SETTLE_CYC clock cycles. No byte is transmitted and no received byte is acted on during that time.
- R2: In the slow listening step (step_code 1), the sequence advances only on three back-to-back received bytes 0x0D, 0x0A, 0x24. A byte that breaks that order keeps step_code at 1.
- R3: A received 0x0D always counts as the first byte of the pattern, so the stream 0x0D 0x0D 0x0A 0x24 is accepted.
- R4: After the slow-rate match, step_code becomes 2. The block then sends "$PASHS,SPD,A,5" followed by 0x0D 0x0A at BAUD_LO, in 8N1 frames with the LSB first.
- R5: Once the last byte of that command is sent, both receive and transmit run at BAUD_HI and step_code is 3. A CR, LF, '$' pattern received at BAUD_HI moves step_code to 4.
- R6: At BAUD_HI the block then sends "$PASHS,NME,ALL,A,OFF" + 0x0D 0x0A with step_code 4, and then "$PASHS,NME,RMC,A,ON" + 0x0D 0x0A with step_code 5.
- R7: After the final LF, step_code is 6. gps_txd stays high and received traffic has no effect until reset.
- R8: If no pattern arrives within LISTEN_CYC cycles of entering a listening step, step_code becomes 7 and stays there, and nothing is transmitted.
- R9: The step codes are: 0 settle, 1 slow listen, 2 rate command, 3 fast listen, 4 mute command, 5 enable command, 6 sleep, 7 fault.
- R10: A low pulse on gps_rxd shorter than half a bit period is rejected at mid start bit and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| gps_rxd | input | 1 | Serial data from the receiver, idle high |
| gps_txd | output | 1 | Serial data to the receiver, idle high |
| step_code | output | 3 | Current sequence step (see R9) |

## Verification
A wrong step shows on step_code at once. The bit or rate that shapes the serial output is harder to see: a wrong rate select or a wrong ROM index appears only when the next frame starts on gps_txd, at most one byte time later. A matcher that drops its restart-on-CR rule, or a receiver that takes a glitch as a start bit, shows up as a listening step that never leaves code 1. The bench decodes every transmitted frame at the rate the requirements call for, and compares it byte for byte with the expected command stream.

// File: rtl/gps_cfg_pkg.sv
package gps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE   = 3'd0,
    ST_HUNT_LO  = 3'd1,
    ST_SEND_SPD = 3'd2,
    ST_HUNT_HI  = 3'd3,
    ST_SEND_OFF = 3'd4,
    ST_SEND_ON  = 3'd5,
    ST_SLEEP    = 3'd6,
    ST_FAULT    = 3'd7
  } step_t;

  localparam int OVS = 16;

  localparam logic [7:0] SYM_CR     = 8'h0D;
  localparam logic [7:0] SYM_LF     = 8'h0A;
  localparam logic [7:0] SYM_DOLLAR = 8'h24;

  // Command stream, three commands back to back, each closed by CR LF
  localparam int CMD_BYTES = 59;
  localparam logic [5:0] SPD_END = 6'd15;
  localparam logic [5:0] OFF_END = 6'd37;
  localparam logic [5:0] ON_END  = 6'd58;

  localparam logic [8*CMD_BYTES-1:0] CMD_ROM = {
    "$PASHS,SPD,A,5", SYM_CR, SYM_LF,
    "$PASHS,NME,ALL,A,OFF", SYM_CR, SYM_LF,
    "$PASHS,NME,RMC,A,ON", SYM_CR, SYM_LF
  };

  // Clock cycles per oversampling tick, never below one
  function automatic int ovs_divider(input int clk_hz, input int baud);
    int d;
    d = clk_hz / (baud * OVS);
    return (d < 1) ? 1 : d;
  endfunction

  // Byte idx of the command stream, idx 0 being the first sent
  function automatic logic [7:0] cmd_byte(input logic [5:0] idx);
    return CMD_ROM[8*(CMD_BYTES-1-int'(idx)) +: 8];
  endfunction

endpackage

// File: rtl/gps_baud_tick.sv
module gps_baud_tick
  import gps_cfg_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int BAUD_LO = 4800,
  parameter int BAUD_HI = 9600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int DIV_LO  = ovs_divider(CLK_HZ, BAUD_LO);
  localparam int DIV_HI  = ovs_divider(CLK_HZ, BAUD_HI);
  localparam int DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int CW      = $clog2(DIV_MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = fast ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign tick   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/gps_uart_rx.sv
module gps_uart_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       byte_stb,
  output logic [7:0] byte_val
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_t;

  rx_t        st;
  logic [1:0] sync;
  logic [3:0] os;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       line;

  assign line     = sync[1];
  assign byte_val = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      st       <= RX_IDLE;
      os       <= '0;
      bitn     <= '0;
      sh       <= '0;
      byte_stb <= 1'b0;
    end else begin
      sync     <= {sync[0], rxd};
      byte_stb <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!line) begin
            st <= RX_START;
            os <= '0;
          end
          RX_START: if (os == 4'd7) begin
            // revalidate at mid start bit
            if (!line) begin
              st   <= RX_DATA;
              os   <= '0;
              bitn <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            os <= os + 1'b1;
          end
          RX_DATA: if (os == 4'd15) begin
            os   <= '0;
            sh   <= {line, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= RX_STOP;
          end else begin
            os <= os + 1'b1;
          end
          default: if (os == 4'd15) begin
            st <= RX_IDLE;
            if (line) byte_stb <= 1'b1;
          end else begin
            os <= os + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/gps_uart_tx.sv
module gps_uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  logic [9:0] fr;
  logic [3:0] os;
  logic [3:0] bitn;

  assign txd = busy ? fr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr   <= '1;
      os   <= '0;
      bitn <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          fr   <= {1'b1, din, 1'b0};
          os   <= '0;
          bitn <= '0;
          busy <= 1'b1;
        end
      end else if (tick) begin
        if (os == 4'd15) begin
          os   <= '0;
          fr   <= {1'b1, fr[9:1]};
          bitn <= bitn + 1'b1;
          if (bitn == 4'd9) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          os <= os + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gps_sync_hunt.sv
module gps_sync_hunt
  import gps_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       stb,
  input  logic [7:0] din,
  output logic       found
);
  logic [1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      found <= 1'b0;
    end else begin
      found <= 1'b0;
      if (clear) begin
        pos <= '0;
      end else if (stb) begin
        if (din == SYM_CR)                        pos <= 2'd1;
        else if (pos == 2'd1 && din == SYM_LF)    pos <= 2'd2;
        else if (pos == 2'd2 && din == SYM_DOLLAR) begin
          pos   <= '0;
          found <= 1'b1;
        end else                                  pos <= '0;
      end
    end
  end
endmodule

// File: rtl/gps_cfg_seq.sv
module gps_cfg_seq
  import gps_cfg_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int BAUD_LO    = 4800,
  parameter int BAUD_HI    = 9600,
  parameter int SETTLE_CYC = 5 * CLK_HZ,
  parameter int LISTEN_CYC = 3 * CLK_HZ
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gps_rxd,
  output logic       gps_txd,
  output logic [2:0] step_code
);
  localparam int TMAX = (SETTLE_CYC > LISTEN_CYC) ? SETTLE_CYC : LISTEN_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  step_t         st;
  logic          fast;
  logic [TW-1:0] tmr;
  logic [5:0]    rom_idx;
  logic          awaiting;

  logic       tick;
  logic       rx_stb;
  logic [7:0] rx_byte;
  logic       hunt_found;
  logic       hunting;
  logic       sending;
  logic       tx_start;
  logic       tx_busy;
  logic       tx_done;
  logic       settle_end;
  logic       listen_end;

  assign hunting    = (st == ST_HUNT_LO) || (st == ST_HUNT_HI);
  assign sending    = (st == ST_SEND_SPD) || (st == ST_SEND_OFF) || (st == ST_SEND_ON);
  assign tx_start   = sending && !tx_busy && !awaiting;
  assign settle_end = (st == ST_SETTLE) && (tmr == TW'(SETTLE_CYC - 1));
  assign listen_end = hunting && (tmr == TW'(LISTEN_CYC - 1));
  assign step_code  = st;

  gps_baud_tick #(.CLK_HZ(CLK_HZ), .BAUD_LO(BAUD_LO), .BAUD_HI(BAUD_HI)) tick_i (
    .clk(clk), .rst_n(rst_n), .fast(fast), .tick(tick)
  );

  gps_uart_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(gps_rxd),
    .byte_stb(rx_stb), .byte_val(rx_byte)
  );

  gps_sync_hunt hunt_i (
    .clk(clk), .rst_n(rst_n), .clear(!hunting), .stb(rx_stb),
    .din(rx_byte), .found(hunt_found)
  );

  gps_uart_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_start),
    .din(cmd_byte(rom_idx)), .txd(gps_txd), .busy(tx_busy), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_SETTLE;
      fast     <= 1'b0;
      tmr      <= '0;
      rom_idx  <= '0;
      awaiting <= 1'b0;
    end else begin
      tmr <= ((st == ST_SETTLE) || hunting) ? tmr + 1'b1 : '0;
      if (tx_start)     awaiting <= 1'b1;
      else if (tx_done) awaiting <= 1'b0;

      case (st)
        ST_SETTLE: if (settle_end) begin
          st  <= ST_HUNT_LO;
          tmr <= '0;
        end
        ST_HUNT_LO: begin
          if (hunt_found) begin
            st      <= ST_SEND_SPD;
            rom_idx <= '0;
          end else if (listen_end) begin
            st <= ST_FAULT;
          end
        end
        ST_SEND_SPD: if (tx_done) begin
          rom_idx <= rom_idx + 1'b1;
          if (rom_idx == SPD_END) begin
            st   <= ST_HUNT_HI;
            fast <= 1'b1;
            tmr  <= '0;
          end
        end
        ST_HUNT_HI: begin
          if (hunt_found)      st <= ST_SEND_OFF;
          else if (listen_end) st <= ST_FAULT;
        end
        ST_SEND_OFF: if (tx_done) begin
          rom_idx <= rom_idx + 1'b1;
          if (rom_idx == OFF_END) st <= ST_SEND_ON;
        end
        ST_SEND_ON: if (tx_done) begin
          rom_idx <= rom_idx + 1'b1;
          if (rom_idx == ON_END) st <= ST_SLEEP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gps_cfg_seq_chk.sv
module gps_cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] step_code,
  input logic       gps_txd,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       hunt_found,
  input logic       fast
);
  // R1
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd0) |-> (gps_txd && !tx_start));

  // R2
  hunt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd2 && $past(step_code) == 3'd1) |-> $past(hunt_found));

  // R4
  frame_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_busy);

  // R5
  fast_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd3 || step_code == 3'd4 || step_code == 3'd5) |-> fast);

  // R5
  slow_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd1 || step_code == 3'd2) |-> !fast);

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd6) |=> (step_code == 3'd6 && gps_txd && !tx_start));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_code == 3'd7) |=> (step_code == 3'd7 && gps_txd && !tx_start));
endmodule

bind gps_cfg_seq gps_cfg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .step_code(step_code), .gps_txd(gps_txd),
  .tx_start(tx_start), .tx_busy(tx_busy), .hunt_found(hunt_found), .fast(fast)
);

// File: tb/gps_cfg_seq_test.sv
`timescale 1ns/1ps
module gps_cfg_seq_test;
  localparam int CLK_HZ  = 153600;
  localparam int SETTLE  = 2000;
  localparam int LISTEN  = 20000;
  localparam int BIT_LO  = 32;
  localparam int BIT_HI  = 16;
  localparam int NBYTES  = 59;

  localparam logic [8*NBYTES-1:0] EXP = {
    "$PASHS,SPD,A,5", 8'h0D, 8'h0A,
    "$PASHS,NME,ALL,A,OFF", 8'h0D, 8'h0A,
    "$PASHS,NME,RMC,A,ON", 8'h0D, 8'h0A
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gps_rxd = 1'b1;
  logic       gps_txd;
  logic [2:0] step_code;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cap [64];
  int cap_n = 0;

  always #2.5 clk = ~clk;

  gps_cfg_seq #(.CLK_HZ(CLK_HZ), .SETTLE_CYC(SETTLE), .LISTEN_CYC(LISTEN)) uut (
    .clk(clk), .rst_n(rst_n), .gps_rxd(gps_rxd), .gps_txd(gps_txd), .step_code(step_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int bc);
    gps_rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      gps_rxd = b[i];
      repeat (bc) @(negedge clk);
    end
    gps_rxd = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic wait_bytes(input int n);
    for (int k = 0; k < 40000 && cap_n < n; k++) @(negedge clk);
  endtask

  // Frame decoder on gps_txd: slow rate for the first command, fast after
  initial begin
    forever begin
      logic [7:0] b;
      int bc;
      @(negedge gps_txd);
      bc = (cap_n < 16) ? BIT_LO : BIT_HI;
      repeat (bc / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (bc) @(negedge clk);
        b[i] = gps_txd;
      end
      repeat (bc) @(negedge clk);
      if (cap_n < 64) cap[cap_n] = b;
      cap_n++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (10) @(negedge clk);
    chk(step_code == 3'd0, "R9 reset step", step_code, 0);
    chk(gps_txd == 1'b1, "R1 reset line idle", gps_txd, 1);
    rst_n = 1'b1;

    // R1: quiet settle, received traffic ignored
    send_byte(8'h0D, BIT_LO); send_byte(8'h0A, BIT_LO); send_byte(8'h24, BIT_LO);
    chk(step_code == 3'd0, "R1 settle step", step_code, 0);
    chk(cap_n == 0, "R1 settle no tx", cap_n, 0);
    repeat (SETTLE - 900) @(negedge clk);
    chk(step_code == 3'd1, "R9 slow listen code", step_code, 1);

    // R2: order broken by other bytes
    send_byte(8'h58, BIT_LO); send_byte(8'h0D, BIT_LO);
    send_byte(8'h0A, BIT_LO); send_byte(8'h58, BIT_LO);
    send_byte(8'h24, BIT_LO);
    repeat (16) @(negedge clk);
    chk(step_code == 3'd1, "R2 broken order holds", step_code, 1);

    // R3 repeated CR, R10 short glitch ignored between LF and '$'
    send_byte(8'h0D, BIT_LO); send_byte(8'h0D, BIT_LO); send_byte(8'h0A, BIT_LO);
    gps_rxd = 1'b0;
    repeat (4) @(negedge clk);
    gps_rxd = 1'b1;
    repeat (48) @(negedge clk);
    send_byte(8'h24, BIT_LO);
    repeat (16) @(negedge clk);
    chk(step_code == 3'd2, "R3 R10 pattern accepted", step_code, 2);

    // R4 rate command at slow rate, then R5 fast listen
    wait_bytes(16);
    repeat (40) @(negedge clk);
    chk(step_code == 3'd3, "R5 fast listen code", step_code, 3);
    send_byte(8'h0D, BIT_HI); send_byte(8'h0A, BIT_HI); send_byte(8'h24, BIT_HI);
    repeat (16) @(negedge clk);
    chk(step_code == 3'd4, "R5 fast pattern accepted", step_code, 4);

    // R6 remaining commands, R7 sleep
    wait_bytes(NBYTES);
    repeat (40) @(negedge clk);
    chk(step_code == 3'd6, "R7 sleep code", step_code, 6);
    chk(cap_n == NBYTES, "R6 byte count", cap_n, NBYTES);
    for (int i = 0; i < NBYTES; i++) begin
      logic [7:0] e;
      e = EXP[8*(NBYTES-1-i) +: 8];
      chk(cap[i] == e, (i < 16) ? "R4 command byte" : "R6 command byte", cap[i], e);
    end

    // R7: traffic in sleep has no effect
    send_byte(8'h0D, BIT_HI); send_byte(8'h0A, BIT_HI); send_byte(8'h24, BIT_HI);
    repeat (400) @(negedge clk);
    chk(cap_n == NBYTES, "R7 no tx in sleep", cap_n, NBYTES);
    chk(step_code == 3'd6, "R7 sleep holds", step_code, 6);

    // R8: silent receiver leads to fault
    rst_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(step_code == 3'd0, "R9 second reset step", step_code, 0);
    rst_n = 1'b1;
    base = cap_n;
    repeat (SETTLE + LISTEN - 1000) @(negedge clk);
    chk(step_code == 3'd1, "R8 not early", step_code, 1);
    repeat (1200) @(negedge clk);
    chk(step_code == 3'd7, "R8 fault code", step_code, 7);
    chk(cap_n == base, "R8 no tx", cap_n, base);
    chk(gps_txd == 1'b1, "R8 line idle", gps_txd, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule